// File: doc/BRIEF.md
# Power-On Reset and Configuration Sequencer

This block brings an SRAM-configured device out of power-up and reset and starts its configuration. An asynchronous power-on pulse resets the sequencer. A stretch counter on the configuration clock then runs for 2^STRETCH_W cycles. During that whole stretch the block sweeps the configuration memory again and again, writing zero to every address.

When the counter reaches its last count, the block samples the active-low reset pin and makes one more full clearing pass. After that pass it either parks in a hold state or starts configuration. In autonomous mode, configuration starts by itself. In host mode, the block waits for a write strobe to the function register. A one-cycle start pulse goes to the configuration loader, and the loader's done strobe brings the device to its running state.

Three trigger pins start partial sequences:

- A rising edge on the manual power-on pin restarts everything.
- A falling edge on the reset pin causes a single clearing pass.
- A falling edge on the reconfigure pin (autonomous mode only) starts configuration again without any clearing.

Top module: `cfg_reset_seq`

## Requirements
- R1: After `pwr_pulse` falls, the block writes the memory on exactly 2^STRETCH_W + DEPTH consecutive cycles. The first 2^STRETCH_W writes are the stretch sweep and the last DEPTH writes are the final pass.
- R2: While `pwr_pulse` is high, `analog_pd` = 1, `loader_rst` = 1, `mem_we` = 0 and `cfg_start` = 0. Whenever `loader_rst` is 1, `analog_pd` is also 1.
- R3: Every write has `mem_wdata` = 0. Write addresses step by one from 0 and wrap from DEPTH-1 back to 0.
- R4: Each clearing pass that follows the stretch or a reset-pin fall starts at address 0 and spans DEPTH writes.
- R5: If the reset pin is low when the stretch ends, the block holds after the final pass: `loader_rst` = 1, `cfg_start` = 0. It leaves hold only after the pin returns high.
- R6: If the reset pin is high when the stretch ends and `auto_mode` = 1, `cfg_start` is high in the cycle right after the last write.
- R7: With `auto_mode` = 0, after the clearing the block waits with `analog_pd` = 1, `loader_rst` = 0 and no start. `cfg_start` pulses in the cycle after `func_wr` is sampled high.
- R8: `cfg_start` is a single-cycle pulse on each entry to configuration. `cfg_done` sampled high while configuring leads to the running state, where `analog_pd` = 0 and `loader_rst` = 0.
- R9: A rising edge on `por_pin` while the reset pin is high restarts the full sequence, including the stretch, the sweep and the final pass.
- R10: A falling edge on the reset pin while `por_pin` is low, seen while waiting, configuring or running, causes one DEPTH-write pass. The block then holds until the pin is high, after which configuration starts.
- R11: A falling edge on `reconf_n_pin` while configuring or running with `auto_mode` = 1 pulses `cfg_start` with no memory write. With `auto_mode` = 0 the same edge has no effect.
- R12: `por_pin`, `rst_n_pin` and `reconf_n_pin` pass through two-flop synchronizers. A change on one of them shows at the outputs on the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| pwr_pulse | input | 1 | Asynchronous power-on pulse, active high, resets the sequencer |
| por_pin | input | 1 | Manual power-on request pin, active high, asynchronous |
| rst_n_pin | input | 1 | External reset pin, active low, asynchronous |
| reconf_n_pin | input | 1 | Reconfigure request pin, falling edge active, asynchronous |
| auto_mode | input | 1 | 1 = autonomous configuration, 0 = wait for host function write |
| func_wr | input | 1 | Host write strobe to the function register, synchronous |
| cfg_done | input | 1 | Loader reports configuration complete, synchronous |
| mem_addr | output | ADDR_W | Configuration memory address |
| mem_we | output | 1 | Configuration memory write enable |
| mem_wdata | output | DATA_W | Configuration memory write data, always zero |
| analog_pd | output | 1 | Analog power-down, high until running |
| loader_rst | output | 1 | Reset to the configuration loader |
| cfg_start | output | 1 | One-cycle pulse starting the loader |

## Verification
Each trigger pin is driven on a falling clock edge. The bench then samples the matching output two rising edges later to confirm it is unchanged, and again after the third rising edge, where the response is due. Synchronous strobes (`func_wr`, `cfg_done`) take effect on the first rising edge, so the result is sampled at the next falling edge. Clearing passes are checked by counting consecutive write cycles against 2^STRETCH_W + DEPTH or DEPTH while following the expected address. The start pulse is due in the very cycle after the last write.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    S_RESET  = 3'd0,
    S_SCRUB  = 3'd1,
    S_FCLR   = 3'd2,
    S_HOLD   = 3'd3,
    S_WAITF  = 3'd4,
    S_CONFIG = 3'd5,
    S_RUN    = 3'd6
  } seq_state_t;

  function automatic logic is_clearing(seq_state_t s);
    return (s == S_SCRUB) || (s == S_FCLR);
  endfunction

  function automatic logic holds_loader(seq_state_t s);
    return (s == S_RESET) || (s == S_SCRUB) || (s == S_FCLR) || (s == S_HOLD);
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int          N    = 3,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] chg
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
        s1_q   <= INIT[i];
        s2_q   <= INIT[i];
        prev_q <= INIT[i];
      end else begin
        s1_q   <= pin[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign lvl[i] = s2_q;
    assign chg[i] = s2_q ^ prev_q;
  end

endmodule

// File: rtl/cfg_stretch_timer.sv
module cfg_stretch_timer #(
  parameter int WIDTH = 17
) (
  input  logic clk,
  input  logic arst,
  input  logic run,
  output logic last
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) cnt_q <= '0;
    else      cnt_q <= run ? cnt_q + 1'b1 : '0;
  end

  assign last = &cnt_q;

endmodule

// File: rtl/cfg_clear_walker.sv
module cfg_clear_walker #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a);
    return (a == TOP) ? '0 : a + 1'b1;
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) addr_q <= '0;
    else      addr_q <= advance ? step_addr(addr_q) : '0;
  end

  assign addr = addr_q;
  assign last = (addr_q == TOP);

endmodule

// File: rtl/cfg_reset_seq.sv
module cfg_reset_seq
  import cfg_seq_pkg::*;
#(
  parameter int STRETCH_W = 17,
  parameter int DEPTH     = 256,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              pwr_pulse,
  input  logic              por_pin,
  input  logic              rst_n_pin,
  input  logic              reconf_n_pin,
  input  logic              auto_mode,
  input  logic              func_wr,
  input  logic              cfg_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              analog_pd,
  output logic              loader_rst,
  output logic              cfg_start
);

  seq_state_t st_q, nxt;
  logic       hold_q, hold_nxt, start_q, go_cfg;
  logic [2:0] pin_lvl, pin_chg;
  logic       por_lvl, rst_lvl;
  logic       por_rise, rst_fall, bfr_fall;
  logic       restart_evt, clear_evt, reconf_evt, roll_evt, pass_evt;
  logic       stretch_last, addr_last, fclr_entry, walk_adv;

  cfg_pin_sync #(.N(3), .INIT(3'b110)) u_sync (
    .clk (clk),
    .arst(pwr_pulse),
    .pin ({reconf_n_pin, rst_n_pin, por_pin}),
    .lvl (pin_lvl),
    .chg (pin_chg)
  );

  assign por_lvl  = pin_lvl[0];
  assign rst_lvl  = pin_lvl[1];
  assign por_rise = pin_chg[0] & pin_lvl[0];
  assign rst_fall = pin_chg[1] & ~pin_lvl[1];
  assign bfr_fall = pin_chg[2] & ~pin_lvl[2];

  assign restart_evt = por_rise & rst_lvl;
  assign clear_evt   = rst_fall & ~por_lvl &
                       ((st_q == S_WAITF) || (st_q == S_CONFIG) || (st_q == S_RUN));
  assign reconf_evt  = bfr_fall & auto_mode & ((st_q == S_CONFIG) || (st_q == S_RUN));
  assign roll_evt    = (st_q == S_SCRUB) & stretch_last;
  assign pass_evt    = (st_q == S_FCLR) & addr_last;

  always_comb begin
    nxt      = st_q;
    hold_nxt = hold_q;
    if (restart_evt) begin
      nxt = S_RESET;
    end else if (clear_evt) begin
      nxt      = S_FCLR;
      hold_nxt = 1'b1;
    end else begin
      unique case (st_q)
        S_RESET: nxt = S_SCRUB;
        S_SCRUB: if (roll_evt) begin
          nxt      = S_FCLR;
          hold_nxt = ~rst_lvl;
        end
        S_FCLR:   if (pass_evt) nxt = hold_q ? S_HOLD : (auto_mode ? S_CONFIG : S_WAITF);
        S_HOLD:   if (rst_lvl)  nxt = auto_mode ? S_CONFIG : S_WAITF;
        S_WAITF:  if (func_wr)  nxt = S_CONFIG;
        S_CONFIG: if (!reconf_evt && cfg_done) nxt = S_RUN;
        S_RUN:    if (reconf_evt) nxt = S_CONFIG;
        default:  nxt = S_RESET;
      endcase
    end
    go_cfg = (nxt == S_CONFIG) && ((st_q != S_CONFIG) || reconf_evt);
  end

  assign fclr_entry = (nxt == S_FCLR) && (st_q != S_FCLR);
  assign walk_adv   = is_clearing(st_q) && is_clearing(nxt) && !fclr_entry;

  cfg_stretch_timer #(.WIDTH(STRETCH_W)) u_timer (
    .clk (clk),
    .arst(pwr_pulse),
    .run ((st_q == S_SCRUB) && (nxt == S_SCRUB)),
    .last(stretch_last)
  );

  cfg_clear_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_walker (
    .clk    (clk),
    .arst   (pwr_pulse),
    .advance(walk_adv),
    .addr   (mem_addr),
    .last   (addr_last)
  );

  always_ff @(posedge clk or posedge pwr_pulse) begin
    if (pwr_pulse) begin
      st_q    <= S_RESET;
      hold_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= nxt;
      hold_q  <= hold_nxt;
      start_q <= go_cfg;
    end
  end

  assign mem_we     = is_clearing(st_q);
  assign mem_wdata  = '0;
  assign analog_pd  = (st_q != S_RUN);
  assign loader_rst = holds_loader(st_q);
  assign cfg_start  = start_q;

endmodule

// File: rtl/cfg_reset_seq_chk.sv
module cfg_reset_seq_chk
  import cfg_seq_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              arst,
  input seq_state_t        st,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              analog_pd,
  input logic              loader_rst,
  input logic              cfg_start,
  input logic              roll_evt,
  input logic              restart_evt,
  input logic              rst_lvl
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  p_zero_data_r3: assert property (@(posedge clk) disable iff (arst)
    mem_we |-> (mem_wdata == '0));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (arst)
    (st == S_SCRUB && $past(st) == S_SCRUB) |->
      (mem_addr == (($past(mem_addr) == TOP) ? '0 : $past(mem_addr) + 1'b1)));

  p_pass_base_r4: assert property (@(posedge clk) disable iff (arst)
    (st == S_FCLR && $past(st) != S_FCLR) |-> (mem_addr == '0));

  p_pd_in_reset_r2: assert property (@(posedge clk) disable iff (arst)
    loader_rst |-> analog_pd);

  p_roll_r1: assert property (@(posedge clk) disable iff (arst)
    (roll_evt && !restart_evt) |=> (st == S_FCLR));

  p_hold_r5: assert property (@(posedge clk) disable iff (arst)
    (st == S_HOLD && !rst_lvl) |=> (st == S_HOLD));

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (arst)
    cfg_start |=> !cfg_start);

  p_start_state_r8: assert property (@(posedge clk) disable iff (arst)
    cfg_start |-> (st == S_CONFIG));

endmodule

bind cfg_reset_seq cfg_reset_seq_chk #(
  .DEPTH (DEPTH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) i_chk (
  .clk        (clk),
  .arst       (pwr_pulse),
  .st         (st_q),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .analog_pd  (analog_pd),
  .loader_rst (loader_rst),
  .cfg_start  (cfg_start),
  .roll_evt   (roll_evt),
  .restart_evt(restart_evt),
  .rst_lvl    (rst_lvl)
);

// File: tb/test_cfg_reset_seq.sv
`timescale 1ns/1ps
module test_cfg_reset_seq;

  localparam int SW    = 9;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int FULL  = (1 << SW) + DEPTH;

  logic          clk = 1'b0;
  logic          pwr_pulse = 1'b0, por_pin = 1'b0, rst_n_pin = 1'b1, reconf_n_pin = 1'b1;
  logic          auto_mode = 1'b1, func_wr = 1'b0, cfg_done = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, analog_pd, loader_rst, cfg_start;
  logic [DW-1:0] mem_wdata;

  int checks = 0, errors = 0, start_cnt = 0, we_cnt = 0;

  always #10 clk = ~clk;

  cfg_reset_seq #(.STRETCH_W(SW), .DEPTH(DEPTH), .DATA_W(DW)) i_cfg_reset_seq (
    .clk(clk), .pwr_pulse(pwr_pulse), .por_pin(por_pin), .rst_n_pin(rst_n_pin),
    .reconf_n_pin(reconf_n_pin), .auto_mode(auto_mode), .func_wr(func_wr),
    .cfg_done(cfg_done), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .analog_pd(analog_pd), .loader_rst(loader_rst), .cfg_start(cfg_start)
  );

  always @(negedge clk) begin
    if (cfg_start) start_cnt++;
    if (mem_we) we_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts one run of consecutive write cycles, following the expected address.
  task automatic run_clear(output int n, output bit addr_ok);
    n = 0; addr_ok = 1'b1;
    for (int w = 0; w < 50 && !mem_we; w++) tick(1);
    while (mem_we && n < 5000) begin
      if (mem_wdata != '0 || int'(mem_addr) != (n % DEPTH)) addr_ok = 1'b0;
      n++;
      tick(1);
    end
  endtask

  task automatic power_up();
    @(negedge clk); pwr_pulse = 1'b1;
    tick(2);
    check(analog_pd && loader_rst && !mem_we && !cfg_start, "R2 reset state",
          {analog_pd, loader_rst, mem_we, cfg_start}, 4'b1100);
    pwr_pulse = 1'b0;
  endtask

  task automatic finish_cfg(input string req);
    cfg_done = 1'b1; tick(1); cfg_done = 1'b0;
    check(!analog_pd && !loader_rst, req, {analog_pd, loader_rst}, 0);
  endtask

  task automatic t_auto_boot();
    int n; bit ok;
    auto_mode = 1'b1; rst_n_pin = 1'b1;
    power_up();
    run_clear(n, ok);
    check(n == FULL, "R1 stretch plus final pass writes", n, FULL);
    check(ok, "R3 zero data and stepping address", ok, 1);
    check(cfg_start, "R6 start right after last write", cfg_start, 1);
    tick(1);
    check(!cfg_start && analog_pd, "R8 start is one cycle", cfg_start, 0);
    finish_cfg("R8 done leads to running");
  endtask

  task automatic t_hold_at_roll();
    int n, s0; bit ok;
    rst_n_pin = 1'b0;
    power_up();
    run_clear(n, ok);
    check(n == FULL, "R5 clearing still completes", n, FULL);
    check(!cfg_start && loader_rst, "R5 held after final pass", cfg_start, 0);
    s0 = start_cnt;
    tick(20);
    check(start_cnt == s0 && loader_rst, "R5 no start while pin low", start_cnt, s0);
    rst_n_pin = 1'b1;
    tick(2);
    check(!cfg_start, "R12 no response before third edge", cfg_start, 0);
    tick(1);
    check(cfg_start, "R5 start after pin high", cfg_start, 1);
    finish_cfg("R8 done leads to running");
  endtask

  task automatic t_por_edge();
    int n; bit ok;
    por_pin = 1'b1;
    tick(2);
    check(!analog_pd, "R12 por not seen before third edge", analog_pd, 0);
    tick(1);
    check(analog_pd && loader_rst, "R9 por edge resets", loader_rst, 1);
    por_pin = 1'b0;
    run_clear(n, ok);
    check(n == FULL, "R9 full sequence after por edge", n, FULL);
    check(cfg_start, "R9 configuration follows", cfg_start, 1);
    finish_cfg("R8 done leads to running");
  endtask

  task automatic t_reset_fall();
    int n; bit ok;
    rst_n_pin = 1'b0;
    tick(2);
    check(!mem_we, "R12 reset fall not seen before third edge", mem_we, 0);
    tick(1);
    check(mem_we && mem_addr == '0, "R4 single pass begins at address 0", mem_addr, 0);
    run_clear(n, ok);
    check(n == DEPTH && ok, "R10 one clearing pass", n, DEPTH);
    check(!cfg_start && loader_rst, "R10 hold while pin low", loader_rst, 1);
    rst_n_pin = 1'b1;
    tick(3);
    check(cfg_start, "R10 start after pin high", cfg_start, 1);
    finish_cfg("R8 done leads to running");
  endtask

  task automatic t_reconf_auto();
    int w0;
    w0 = we_cnt;
    reconf_n_pin = 1'b0;
    tick(2);
    check(!cfg_start, "R12 reconfigure not seen early", cfg_start, 0);
    tick(1);
    check(cfg_start && !loader_rst, "R11 reconfigure starts loader", cfg_start, 1);
    reconf_n_pin = 1'b1;
    check(we_cnt == w0, "R11 no writes on reconfigure", we_cnt, w0);
    finish_cfg("R8 done leads to running");
  endtask

  task automatic t_micro();
    int n, s0; bit ok;
    auto_mode = 1'b0;
    power_up();
    run_clear(n, ok);
    check(n == FULL && !cfg_start, "R7 clearing then no start", n, FULL);
    s0 = start_cnt;
    tick(5);
    check(start_cnt == s0 && analog_pd && !loader_rst, "R7 waiting for function write",
          start_cnt, s0);
    func_wr = 1'b1; tick(1); func_wr = 1'b0;
    check(cfg_start, "R7 start after function write", cfg_start, 1);
    finish_cfg("R8 done leads to running");
  endtask

  task automatic t_reconf_micro();
    int s0;
    s0 = start_cnt;
    reconf_n_pin = 1'b0;
    tick(5);
    check(start_cnt == s0 && !analog_pd, "R11 reconfigure ignored in host mode",
          start_cnt, s0);
    reconf_n_pin = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_auto_boot();
    t_hold_at_roll();
    t_por_edge();
    t_reset_fall();
    t_reconf_auto();
    t_micro();
    t_reconf_micro();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule